// File: doc/BRIEF.md
# Flash Fault Flag and Interrupt Controller

This block sits beside the read path of a flash array. It collects three kinds of event. The ECC checker reports single-bit and double-bit faults on each array read, and the command sequencer reports command completion. From these it keeps sticky fault flags and drives three level interrupt requests.

Firmware reaches the block through a byte-wide register port. The port holds three registers:

- a configuration register, which holds the command-complete interrupt enable, a single-fault ignore control and two fault-injection controls;
- an error-enable register, which holds one interrupt enable per fault flag;
- an error-status register, which holds the fault flags.

The injection controls let firmware drive its error handlers on any array read without a real fault in the array.

Writes take effect at the clock edge. The read port is combinational on the selected address, and the interrupt outputs are combinational on the registered state.

Top module: `flash_fault_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0x00 and all interrupt outputs are low.
- R2: Register addresses are 0 for configuration, 1 for error-enable and 2 for error-status; address 3 reads 0x00. Configuration bits are: bit 7 command-complete enable, bit 4 ignore single faults, bit 1 force double fault, bit 0 force single fault. Bits 6, 5, 3 and 2 read 0 and ignore writes.
- R3: Error-enable bit 0 enables the single-fault interrupt and bit 1 enables the double-fault interrupt. Its other bits read 0 and ignore writes.
- R4: `irq_cmd` is high in the same cycle that both `cmd_done` and the command-complete enable are high, and low otherwise.
- R5: An array read (`arr_rd`) with `ecc_sgl` high, while ignore is 0, sets error-status bit 0 from the next cycle.
- R6: While ignore is 1, an array read with `ecc_sgl` high leaves error-status bit 0 clear.
- R7: An array read with `ecc_dbl` high sets error-status bit 1 from the next cycle.
- R8: While force-double is 1, every array read sets error-status bit 1; cycles without an array read set nothing.
- R9: While force-single is 1, every array read sets error-status bit 0, even while ignore is 1.
- R10: Force bits stay 1 until software writes 0 to them; array reads and status writes do not clear them.
- R11: Writing 1 to an error-status bit clears it; writing 0 leaves it unchanged.
- R12: When a flag's set event and its clear-by-write fall in the same cycle, the flag ends up set.
- R13: `irq_sgl` and `irq_dbl` equal their flag ANDed with their enable, and they drop in the cycle right after the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| arr_rd | input | 1 | Array read completes this cycle |
| ecc_sgl | input | 1 | Single-bit fault on this read |
| ecc_dbl | input | 1 | Double-bit fault on this read |
| cmd_done | input | 1 | Command-complete flag level from the sequencer |
| irq_cmd | output | 1 | Command-complete interrupt request |
| irq_sgl | output | 1 | Single-fault interrupt request |
| irq_dbl | output | 1 | Double-fault interrupt request |

## Verification
Register writes and read events land at the rising edge. Their results therefore show on `reg_rdata` and on the fault interrupts during the next cycle. `irq_cmd` instead follows `cmd_done` within the same cycle.

Each vector drives its inputs at a falling edge and waits for one rising edge. The bench then drops the strobes, keeps `cmd_done` steady and selects the status register, and it samples 3 ns after that edge. This means every check reads the state exactly one edge after its stimulus. The same-cycle set/clear collision and the one-cycle interrupt drop are each covered by a dedicated vector.

// File: rtl/ffc_pkg.sv
// Package: shared addresses, bit positions and the configuration record
// for the flash fault controller. Assumes an 8-bit register port.
package ffc_pkg;
    localparam int NUM_FLT   = 2;
    localparam int FLT_SGL   = 0;
    localparam int FLT_DBL   = 1;
    localparam int ADR_CFG   = 0;
    localparam int ADR_ENA   = 1;
    localparam int ADR_STAT  = 2;
    localparam int CB_CCE    = 7;
    localparam int CB_IGN    = 4;
    localparam int CB_FDBL   = 1;
    localparam int CB_FSGL   = 0;

    typedef struct packed {
        logic cce;
        logic ign;
        logic frc_dbl;
        logic frc_sgl;
    } cfg_t;
endpackage

// File: rtl/ffc_cfg_regs.sv
// Module: holds the configuration and error-enable registers.
// Assumes writes are single-cycle strobes; reserved bits are not stored.
module ffc_cfg_regs
    import ffc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output cfg_t               cfg,
    output logic [NUM_FLT-1:0] flt_en
);
    logic wr_cfg;
    logic wr_ena;

    // Decode which register this write targets.
    always_comb begin
        wr_cfg = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
        wr_ena = wr_en && (wr_addr == ADDR_W'(ADR_ENA));
    end

    // Configuration register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_cfg) begin
            cfg.cce     <= wr_data[CB_CCE];
            cfg.ign     <= wr_data[CB_IGN];
            cfg.frc_dbl <= wr_data[CB_FDBL];
            cfg.frc_sgl <= wr_data[CB_FSGL];
        end
    end

    // Error-enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n) flt_en <= '0;
        else if (wr_ena) flt_en <= wr_data[NUM_FLT-1:0];
    end

    // R10
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.frc_dbl && !wr_cfg) |=> cfg.frc_dbl);
    // R10
    force_s_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.frc_sgl && !wr_cfg) |=> cfg.frc_sgl);
endmodule

// File: rtl/ffc_flag_bank.sv
// Module: a bank of sticky fault flags, one per fault type.
// Assumes set and clear requests are single-cycle; set has priority.
module ffc_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set wins over write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        // R12
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
        // R11
        keep_on_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        // R11
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/ffc_irq_gate.sv
// Module: gates each flag with its enable to form level interrupt requests.
// Assumes inputs are registered state or a level from the sequencer.
module ffc_irq_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    input  logic         cce,
    input  logic         cmd_flag,
    output logic [N-1:0] irq_flt,
    output logic         irq_cmd
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        // One fault request line.
        always_comb irq_flt[i] = flag[i] & en[i];
    end

    // Command-complete request line.
    always_comb irq_cmd = cce & cmd_flag;
endmodule

// File: rtl/flash_fault_ctrl.sv
// Module: top of the flash fault controller. It turns array-read events
// into flag sets, decodes status writes into clears and muxes register reads.
// Assumes one array read per cycle at most and an 8-bit data port.
module flash_fault_ctrl
    import ffc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              arr_rd,
    input  logic              ecc_sgl,
    input  logic              ecc_dbl,
    input  logic              cmd_done,
    output logic              irq_cmd,
    output logic              irq_sgl,
    output logic              irq_dbl
);
    cfg_t               cfg;
    logic [NUM_FLT-1:0] flt_en;
    logic [NUM_FLT-1:0] flag_set;
    logic [NUM_FLT-1:0] flag_clr;
    logic [NUM_FLT-1:0] flags;
    logic [NUM_FLT-1:0] irq_flt;

    ffc_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .cfg(cfg), .flt_en(flt_en)
    );

    // Form flag set requests from the read event, ECC results and injection.
    always_comb begin
        flag_set[FLT_SGL] = arr_rd && ((ecc_sgl && !cfg.ign) || cfg.frc_sgl);
        flag_set[FLT_DBL] = arr_rd && (ecc_dbl || cfg.frc_dbl);
    end

    // Decode write-one-to-clear requests on the status register.
    always_comb begin
        flag_clr = '0;
        if (reg_wr && reg_addr == ADDR_W'(ADR_STAT))
            flag_clr = reg_wdata[NUM_FLT-1:0];
    end

    ffc_flag_bank #(.N(NUM_FLT)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr),
        .flag_q(flags)
    );

    ffc_irq_gate #(.N(NUM_FLT)) u_irq (
        .flag(flags), .en(flt_en), .cce(cfg.cce), .cmd_flag(cmd_done),
        .irq_flt(irq_flt), .irq_cmd(irq_cmd)
    );

    // Drive the fault request outputs.
    always_comb begin
        irq_sgl = irq_flt[FLT_SGL];
        irq_dbl = irq_flt[FLT_DBL];
    end

    // Read mux; unused and reserved bits return 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_CFG): begin
                reg_rdata[CB_CCE]  = cfg.cce;
                reg_rdata[CB_IGN]  = cfg.ign;
                reg_rdata[CB_FDBL] = cfg.frc_dbl;
                reg_rdata[CB_FSGL] = cfg.frc_sgl;
            end
            ADDR_W'(ADR_ENA):  reg_rdata[NUM_FLT-1:0] = flt_en;
            ADDR_W'(ADR_STAT): reg_rdata[NUM_FLT-1:0] = flags;
            default:           reg_rdata = '0;
        endcase
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADR_CFG)) |-> (reg_rdata[6:5] == 2'b00 && reg_rdata[3:2] == 2'b00));
    // R5
    sgl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && ecc_sgl && !cfg.ign) |=> flags[FLT_SGL]);
    // R6
    ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[FLT_SGL] && cfg.ign && !cfg.frc_sgl) |=> !flags[FLT_SGL]);
    // R7
    dbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && ecc_dbl) |=> flags[FLT_DBL]);
    // R8
    frc_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && cfg.frc_dbl) |=> flags[FLT_DBL]);
    // R9
    frc_sgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && cfg.frc_sgl) |=> flags[FLT_SGL]);
    // R4
    cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> !irq_cmd);
    // R13
    sgl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FLT_SGL]) |-> !irq_sgl);
    // R13
    dbl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FLT_DBL]) |-> !irq_dbl);
endmodule

// File: tb/flash_fault_ctrl_bench.sv
module flash_fault_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       arr_rd, ecc_sgl, ecc_dbl, cmd_done;
    logic       irq_cmd, irq_sgl, irq_dbl;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_fault_ctrl u_flash_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_rd(arr_rd),
        .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl), .cmd_done(cmd_done),
        .irq_cmd(irq_cmd), .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
    );

    // Vector: {req[3:0], wr, addr[1:0], wdata[7:0], rd, sgl, dbl, cmd, exp_stat[1:0], exp_irq{cmd,dbl,sgl}}
    localparam int NV = 23;
    localparam logic [23:0] VEC [NV] = '{
        {4'd3,  1'b1, 2'd1, 8'h03, 4'b0000, 2'b00, 3'b000}, // R3 enable both faults
        {4'd5,  1'b0, 2'd0, 8'h00, 4'b1100, 2'b01, 3'b001}, // R5 single fault
        {4'd11, 1'b1, 2'd2, 8'h00, 4'b0000, 2'b01, 3'b001}, // R11 write 0 keeps
        {4'd13, 1'b1, 2'd2, 8'h01, 4'b0000, 2'b00, 3'b000}, // R13 drop after clear
        {4'd7,  1'b0, 2'd0, 8'h00, 4'b1010, 2'b10, 3'b010}, // R7 double fault
        {4'd12, 1'b1, 2'd2, 8'h02, 4'b1010, 2'b10, 3'b010}, // R12 set wins
        {4'd11, 1'b1, 2'd2, 8'h02, 4'b0000, 2'b00, 3'b000}, // R11 clear
        {4'd2,  1'b1, 2'd0, 8'h10, 4'b0000, 2'b00, 3'b000}, // R2 ignore on
        {4'd6,  1'b0, 2'd0, 8'h00, 4'b1100, 2'b00, 3'b000}, // R6 suppressed
        {4'd2,  1'b1, 2'd0, 8'h12, 4'b0000, 2'b00, 3'b000}, // R2 force double on
        {4'd8,  1'b0, 2'd0, 8'h00, 4'b0000, 2'b00, 3'b000}, // R8 no read no set
        {4'd8,  1'b0, 2'd0, 8'h00, 4'b1000, 2'b10, 3'b010}, // R8 forced double
        {4'd10, 1'b1, 2'd2, 8'h02, 4'b0000, 2'b00, 3'b000}, // R10 status write
        {4'd10, 1'b0, 2'd0, 8'h00, 4'b1000, 2'b10, 3'b010}, // R10 force persists
        {4'd2,  1'b1, 2'd0, 8'h11, 4'b0000, 2'b10, 3'b010}, // R2 force single + ignore
        {4'd11, 1'b1, 2'd2, 8'h02, 4'b0000, 2'b00, 3'b000}, // R11 clear double
        {4'd9,  1'b0, 2'd0, 8'h00, 4'b1000, 2'b01, 3'b001}, // R9 forced over ignore
        {4'd10, 1'b1, 2'd0, 8'h80, 4'b0000, 2'b01, 3'b001}, // R10 write 0 ends force
        {4'd4,  1'b0, 2'd0, 8'h00, 4'b0001, 2'b01, 3'b101}, // R4 cmd irq
        {4'd11, 1'b1, 2'd2, 8'h01, 4'b0000, 2'b00, 3'b000}, // R11 clear single
        {4'd10, 1'b0, 2'd0, 8'h00, 4'b1000, 2'b00, 3'b000}, // R10 forces gone
        {4'd13, 1'b1, 2'd1, 8'h00, 4'b1100, 2'b01, 3'b000}, // R13 enable gates
        {4'd4,  1'b1, 2'd0, 8'h00, 4'b0001, 2'b01, 3'b000}  // R4 enable off
    };

    task automatic check(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        arr_rd = 0; ecc_sgl = 0; ecc_dbl = 0; cmd_done = 0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input int req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, "rdata", reg_rdata, exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R1 watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(1, 2'd0, 8'h00);
        rd_chk(1, 2'd1, 8'h00);
        rd_chk(1, 2'd2, 8'h00);
        check(1, "irqs", {5'b0, irq_cmd, irq_dbl, irq_sgl}, 8'h00);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr    = VEC[i][19];
            reg_addr  = VEC[i][18:17];
            reg_wdata = VEC[i][16:9];
            arr_rd    = VEC[i][8];
            ecc_sgl   = VEC[i][7];
            ecc_dbl   = VEC[i][6];
            cmd_done  = VEC[i][5];
            @(posedge clk);
            #2;
            reg_wr = 0; arr_rd = 0; ecc_sgl = 0; ecc_dbl = 0;
            reg_addr = 2'd2;
            #1;
            check(int'(VEC[i][23:20]), "status", reg_rdata, {6'b0, VEC[i][4:3]});
            check(int'(VEC[i][23:20]), "irqs", {5'b0, irq_cmd, irq_dbl, irq_sgl}, {5'b0, VEC[i][2:0]});
        end
        idle();

        // R2 reserved bits and unused address
        wr_reg(2'd0, 8'hFF);
        rd_chk(2, 2'd0, 8'h93);
        rd_chk(2, 2'd3, 8'h00);
        wr_reg(2'd3, 8'hFF);
        rd_chk(2, 2'd3, 8'h00);
        // R3 error-enable reserved bits
        wr_reg(2'd1, 8'hFF);
        rd_chk(3, 2'd1, 8'h03);

        // R1 reset clears everything mid-run
        @(negedge clk);
        arr_rd = 1;
        @(negedge clk);
        arr_rd = 0;
        rd_chk(1, 2'd2, 8'h03);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rd_chk(1, 2'd0, 8'h00);
        rd_chk(1, 2'd1, 8'h00);
        rd_chk(1, 2'd2, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule